// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block turns parallel bytes from a host into an asynchronous serial stream. The host presents a byte with a one-cycle write strobe, and the byte lands in a one-entry holding register. Whenever the frame engine is idle, or is just finishing the last stop tick of a frame, the waiting byte moves into the shifter. The shifter then sends one frame: a low start bit, the data bits least significant first, an optional parity bit, and one, one and a half or two stop bits. Every bit lasts 16 periods of an externally supplied 16x baud strobe (`tick16`).

The frame format comes from line-control inputs: a 2-bit length field, a stop-select bit, parity enable, even select and a parity-fix control. The block captures these fields at the moment a byte enters the shifter, so they stay constant for the whole of that frame. A break control and a loopback control act on the line driver only. Break pulls the line low at once and leaves the frame sequence running. Loopback parks the external pin at 1 and sends the frame to a tap used for self-test.

The frame engine is a state machine with five states. In IDLE the engine waits, and it goes to START when the holding register is full. In START it sends the low start bit for 16 ticks and then goes to DATA. In DATA it sends the data bits. After the last data bit it goes to PARITY if parity is enabled, and to STOP if not. PARITY sends the parity bit for 16 ticks and then goes to STOP. STOP holds the line high for the selected stop length. It then goes to START, taking the next byte on the same edge, if one is waiting, and to IDLE if none is.

Top module: `async_tx`

## Requirements
- R1: During reset and after reset with no writes, `txd` and `loop_txd` are 1, and `hold_empty` and `tx_empty` are 1.
- R2: A frame is a 0 start bit, then the data bits with bit 0 first, then the parity bit when enabled, then stop bits at 1. Each bit lasts exactly 16 `tick16` pulses.
- R3: `len_sel` gives the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the selected length are not sent.
- R4: With `stop_sel`=0 the stop lasts 16 ticks. With `stop_sel`=1 it lasts 24 ticks for 5-bit words and 32 ticks for 6, 7 and 8-bit words.
- R5: With `par_en`=1 and `par_fix`=0, `par_even`=1 gives even parity and `par_even`=0 gives odd parity over the sent data bits. With `par_fix`=1, `par_even`=0 sends a 1 parity bit and `par_even`=1 sends a 0.
- R6: `hold_empty` goes to 0 on the clock edge that samples `wr_en`=1. It returns to 1 on the edge that moves the byte into the shifter. From IDLE, this move happens on the clock edge after the write.
- R7: `tx_empty` is 1 only when the holding register is empty and no frame is in progress.
- R8: If a byte is waiting when the last stop tick of a frame arrives, the next start bit begins with that tick, and there is no idle gap.
- R9: While `send_break`=1, `txd` and `loop_txd` are 0 in the same cycle. The frame timing continues, and after release the line shows the rest of the frame where it is due.
- R10: With `loop_mode`=1, `txd` is held at 1 and `loop_txd` carries the frame. With `loop_mode`=0, `txd` equals `loop_txd`.
- R11: The format fields are captured when a byte enters the shifter. Changes made during a frame apply only to later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | One-cycle byte write strobe |
| wr_data | input | 8 | Byte to send |
| tick16 | input | 1 | One-cycle pulse at 16 times the bit rate |
| len_sel | input | 2 | Data length: 00=5, 01=6, 10=7, 11=8 bits |
| stop_sel | input | 1 | Long stop select |
| par_en | input | 1 | Parity enable |
| par_even | input | 1 | Even-parity select; value select when fixed |
| par_fix | input | 1 | Fixed parity value |
| send_break | input | 1 | Force the line low |
| loop_mode | input | 1 | Send the frame to the tap, park the pin high |
| txd | output | 1 | Serial line |
| loop_txd | output | 1 | Loopback data tap |
| hold_empty | output | 1 | Holding register empty |
| tx_empty | output | 1 | Holding register and shifter both empty |

## Verification
The line outputs are combinational from the frame state registers and from the break and loopback inputs. A tick therefore shows on `txd` in the cycle after the clock edge that samples it, and a break or loopback change shows in the same cycle it is applied. `hold_empty` and `tx_empty` change one edge after a write or a transfer. The bench model advances its per-tick bit queue on the same edges as the design. It compares all four outputs at every falling clock edge, half a cycle after those updates. Directed checks wait a fixed number of falling edges after a write to observe the write edge and then the transfer edge.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } tx_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic       stop_long;
        logic       par_en;
        logic       par_even;
        logic       par_fix;
    } tx_fmt_t;

endpackage

// File: rtl/async_tx_hold.sv
module async_tx_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic         full,
    output logic [W-1:0] data
);

    logic         full_q;
    logic [W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else begin
            if (wr_en) begin
                full_q <= 1'b1;
                data_q <= wr_data;
            end else if (take) begin
                full_q <= 1'b0;
            end
        end
    end

    assign full = full_q;
    assign data = data_q;

endmodule

// File: rtl/async_tx_frame.sv
module async_tx_frame
    import async_tx_pkg::*;
#(
    parameter int W   = 8,
    parameter int OVS = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         hold_full,
    input  logic [W-1:0] hold_data,
    input  tx_fmt_t      fmt,
    output logic         take,
    output logic         busy,
    output logic         frame_bit
);

    localparam int CNT_W = $clog2(2 * OVS);
    localparam int IDX_W = $clog2(W);
    localparam logic [CNT_W-1:0] BIT_LAST    = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] STOP15_LAST = CNT_W'(OVS + OVS / 2 - 1);
    localparam logic [CNT_W-1:0] STOP2_LAST  = CNT_W'(2 * OVS - 1);
    localparam logic [IDX_W-1:0] IDX_BASE    = IDX_W'(W - 4);

    tx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;
    logic [W-1:0]     sh_q;
    tx_fmt_t          fmt_q;
    logic             par_q;

    logic             bit_end;
    logic             stop_end;
    logic             seg_end;
    logic [CNT_W-1:0] stop_last;
    logic [IDX_W-1:0] data_last;

    function automatic logic par_calc(input logic [W-1:0] d, input tx_fmt_t f);
        logic x;
        x = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (i < (W - 3 + int'(f.len))) x = x ^ d[i];
        end
        if (f.par_fix) return !f.par_even;
        return f.par_even ? x : !x;
    endfunction

    always_comb begin
        stop_last = BIT_LAST;
        if (fmt_q.stop_long) begin
            stop_last = (fmt_q.len == 2'b00) ? STOP15_LAST : STOP2_LAST;
        end
        data_last = IDX_BASE + IDX_W'(fmt_q.len);
        bit_end   = tick && (cnt_q == BIT_LAST);
        stop_end  = tick && (cnt_q == stop_last);
        seg_end   = (state_q == ST_STOP) ? stop_end : bit_end;
        take      = hold_full && ((state_q == ST_IDLE) ||
                                  ((state_q == ST_STOP) && stop_end));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hold_full) state_d = ST_START;
            end
            ST_START: begin
                if (bit_end) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (bit_end && (idx_q == data_last)) begin
                    state_d = fmt_q.par_en ? ST_PARITY : ST_STOP;
                end
            end
            ST_PARITY: begin
                if (bit_end) state_d = ST_STOP;
            end
            ST_STOP: begin
                if (stop_end) state_d = hold_full ? ST_START : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
            sh_q  <= '0;
            fmt_q <= '0;
            par_q <= 1'b0;
        end else if (take) begin
            cnt_q <= '0;
            idx_q <= '0;
            sh_q  <= hold_data;
            fmt_q <= fmt;
            par_q <= par_calc(hold_data, fmt);
        end else if ((state_q != ST_IDLE) && tick) begin
            cnt_q <= seg_end ? '0 : cnt_q + 1'b1;
            if ((state_q == ST_DATA) && bit_end) begin
                sh_q  <= sh_q >> 1;
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    always_comb begin
        busy = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE:   frame_bit = 1'b1;
            ST_START:  frame_bit = 1'b0;
            ST_DATA:   frame_bit = sh_q[0];
            ST_PARITY: frame_bit = par_q;
            ST_STOP:   frame_bit = 1'b1;
            default:   frame_bit = 1'b1;
        endcase
    end

endmodule

// File: rtl/async_tx_line.sv
module async_tx_line (
    input  logic frame_bit,
    input  logic send_break,
    input  logic loop_mode,
    output logic txd,
    output logic loop_txd
);

    always_comb begin
        loop_txd = send_break ? 1'b0 : frame_bit;
        txd      = loop_mode ? 1'b1 : loop_txd;
    end

endmodule

// File: rtl/async_tx.sv
module async_tx
    import async_tx_pkg::*;
#(
    parameter int W   = 8,
    parameter int OVS = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         tick16,
    input  logic [1:0]   len_sel,
    input  logic         stop_sel,
    input  logic         par_en,
    input  logic         par_even,
    input  logic         par_fix,
    input  logic         send_break,
    input  logic         loop_mode,
    output logic         txd,
    output logic         loop_txd,
    output logic         hold_empty,
    output logic         tx_empty
);

    logic         hold_full;
    logic [W-1:0] hold_data;
    logic         take;
    logic         busy;
    logic         frame_bit;
    tx_fmt_t      fmt;

    assign fmt = '{len: len_sel, stop_long: stop_sel, par_en: par_en,
                   par_even: par_even, par_fix: par_fix};

    async_tx_hold #(.W(W)) hold_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    async_tx_frame #(.W(W), .OVS(OVS)) frame_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .fmt       (fmt),
        .take      (take),
        .busy      (busy),
        .frame_bit (frame_bit)
    );

    async_tx_line line_i (
        .frame_bit  (frame_bit),
        .send_break (send_break),
        .loop_mode  (loop_mode),
        .txd        (txd),
        .loop_txd   (loop_txd)
    );

    assign hold_empty = !hold_full;
    assign tx_empty   = !hold_full && !busy;

endmodule

// File: rtl/async_tx_chk.sv
module async_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic send_break,
    input logic loop_mode,
    input logic txd,
    input logic loop_txd,
    input logic hold_empty,
    input logic tx_empty
);

    // R6
    write_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !hold_empty);

    // R7
    empty_implies_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> hold_empty);

    // R6
    transfer_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_empty) |-> !tx_empty);

    // R2
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !send_break && !loop_mode) |-> txd);

    // R9
    break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        send_break |-> (!loop_txd && (loop_mode || !txd)));

    // R10
    loop_pin_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loop_mode |-> txd);

endmodule

bind async_tx async_tx_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .send_break (send_break),
    .loop_mode  (loop_mode),
    .txd        (txd),
    .loop_txd   (loop_txd),
    .hold_empty (hold_empty),
    .tx_empty   (tx_empty)
);

// File: tb/async_tx_tb_top.sv
module async_tx_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tick16 = 1'b0;
    logic [1:0] len_sel = 2'b11;
    logic       stop_sel = 1'b0;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       par_fix = 1'b0;
    logic       send_break = 1'b0;
    logic       loop_mode = 1'b0;
    logic       txd, loop_txd, hold_empty, tx_empty;

    int checks = 0;
    int fails  = 0;
    string phase = "R1";

    bit   q[$];
    bit   m_full = 1'b0;
    logic [7:0] m_data = 8'h00;

    always #4 clk = ~clk;

    async_tx dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tick16(tick16), .len_sel(len_sel), .stop_sel(stop_sel),
        .par_en(par_en), .par_even(par_even), .par_fix(par_fix),
        .send_break(send_break), .loop_mode(loop_mode),
        .txd(txd), .loop_txd(loop_txd), .hold_empty(hold_empty), .tx_empty(tx_empty)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic build_frame(input logic [7:0] d);
        int  nb;
        bit  x;
        bit  p;
        int  stop_t;
        nb = 5 + int'(len_sel);
        x = 1'b0;
        repeat (16) q.push_back(1'b0);
        for (int i = 0; i < nb; i++) begin
            x = x ^ d[i];
            repeat (16) q.push_back(d[i]);
        end
        if (par_en) begin
            if (par_fix) p = !par_even;
            else         p = par_even ? x : !x;
            repeat (16) q.push_back(p);
        end
        stop_t = !stop_sel ? 16 : ((len_sel == 2'b00) ? 24 : 32);
        repeat (stop_t) q.push_back(1'b1);
    endtask

    // Behavioural reference: one queue entry per tick slot of the line.
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            m_full = 1'b0;
            m_data = 8'h00;
        end else begin
            bit         was_full;
            logic [7:0] was_data;
            bit         load;
            was_full = m_full;
            was_data = m_data;
            load = 1'b0;
            if (q.size() == 0) begin
                load = was_full;
            end else if (tick16) begin
                void'(q.pop_front());
                if (q.size() == 0) load = was_full;
            end
            if (load) begin
                build_frame(was_data);
                m_full = 1'b0;
            end
            if (wr_en) begin
                m_full = 1'b1;
                m_data = wr_data;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit fb, tap, pin, emp;
            fb  = (q.size() != 0) ? q[0] : 1'b1;
            tap = send_break ? 1'b0 : fb;
            pin = loop_mode ? 1'b1 : tap;
            emp = !m_full && (q.size() == 0);
            chk(txd === pin, {phase, " txd"}, int'(txd), int'(pin));
            chk(loop_txd === tap, {phase, " loop_txd"}, int'(loop_txd), int'(tap));
            chk(hold_empty === !m_full, "R6 hold_empty", int'(hold_empty), int'(!m_full));
            chk(tx_empty === emp, "R7 tx_empty", int'(tx_empty), int'(emp));
        end
    end

    initial begin
        forever begin
            repeat (3) @(posedge clk);
            #1 tick16 = 1'b1;
            @(posedge clk);
            #1 tick16 = 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired in phase %s actual=1 expected=0", phase);
        report();
    end

    task automatic send(input logic [7:0] b);
        @(posedge clk); #1;
        wr_en = 1'b1;
        wr_data = b;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        while (!(q.size() == 0 && !m_full)) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic set_fmt(input logic [1:0] l, input bit s, input bit pe,
                           input bit ev, input bit fx);
        @(posedge clk); #1;
        len_sel = l; stop_sel = s; par_en = pe; par_even = ev; par_fix = fx;
    endtask

    initial begin
        bit prev;
        // R1: reset values
        repeat (3) @(negedge clk);
        chk(txd === 1'b1 && loop_txd === 1'b1, "R1 line in reset", int'(txd), 1);
        chk(hold_empty === 1'b1 && tx_empty === 1'b1, "R1 flags in reset", int'(tx_empty), 1);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(txd === 1'b1 && tx_empty === 1'b1, "R1 idle after reset", int'(txd), 1);

        // R6 and R7 directed, then R2 frame
        phase = "R2";
        set_fmt(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        send(8'hA5);
        @(negedge clk);
        chk(hold_empty === 1'b0, "R6 write clears hold_empty", int'(hold_empty), 0);
        @(negedge clk);
        chk(hold_empty === 1'b1, "R6 transfer sets hold_empty", int'(hold_empty), 1);
        chk(tx_empty === 1'b0, "R7 busy shifter", int'(tx_empty), 0);
        chk(txd === 1'b0, "R2 start bit low", int'(txd), 0);
        wait_idle();
        chk(tx_empty === 1'b1, "R7 empty after frame", int'(tx_empty), 1);

        // R3 word lengths
        phase = "R3";
        for (int l = 0; l < 3; l++) begin
            set_fmt(2'(l), 1'b0, 1'b0, 1'b0, 1'b0);
            send(8'hFC);
            wait_idle();
        end

        // R4 stop lengths
        phase = "R4";
        set_fmt(2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
        send(8'h13);
        wait_idle();
        set_fmt(2'b11, 1'b1, 1'b0, 1'b0, 1'b0);
        send(8'h81);
        wait_idle();
        set_fmt(2'b01, 1'b1, 1'b0, 1'b0, 1'b0);
        send(8'h2A);
        wait_idle();

        // R5 parity modes
        phase = "R5";
        for (int m = 0; m < 4; m++) begin
            set_fmt(2'b11, 1'b0, 1'b1, m[0], m[1]);
            send(8'h5B);
            wait_idle();
            set_fmt(2'b10, 1'b0, 1'b1, m[0], m[1]);
            send(8'h07);
            wait_idle();
        end

        // R8 back-to-back frames
        phase = "R8";
        set_fmt(2'b11, 1'b0, 1'b1, 1'b1, 1'b0);
        send(8'h3C);
        repeat (4) @(posedge clk);
        send(8'hC3);
        @(negedge clk);
        chk(hold_empty === 1'b0, "R8 second byte waiting", int'(hold_empty), 0);
        prev = txd;
        while (hold_empty !== 1'b1) begin
            prev = txd;
            @(negedge clk);
        end
        chk(prev === 1'b1 && txd === 1'b0, "R8 start follows stop", int'(txd), 0);
        chk(tx_empty === 1'b0, "R8 still busy", int'(tx_empty), 0);
        wait_idle();

        // R9 break mid-frame
        phase = "R9";
        set_fmt(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        send(8'hFF);
        repeat (150) @(posedge clk);
        #1 send_break = 1'b1;
        @(negedge clk);
        chk(txd === 1'b0 && loop_txd === 1'b0, "R9 break immediate", int'(txd), 0);
        repeat (80) @(posedge clk);
        #1 send_break = 1'b0;
        @(negedge clk);
        chk(txd === 1'b1, "R9 data resumes after break", int'(txd), 1);
        wait_idle();

        // R10 loopback
        phase = "R10";
        @(posedge clk); #1 loop_mode = 1'b1;
        send(8'h96);
        repeat (40) @(negedge clk);
        chk(txd === 1'b1 && loop_txd === 1'b0, "R10 pin parked, tap active", int'(loop_txd), 0);
        wait_idle();
        @(posedge clk); #1 loop_mode = 1'b0;

        // R11 format capture
        phase = "R11";
        set_fmt(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        send(8'hF0);
        repeat (30) @(posedge clk);
        set_fmt(2'b00, 1'b1, 1'b1, 1'b1, 1'b1);
        send(8'h0F);
        wait_idle();

        report();
    end

endmodule